// File: doc/BRIEF.md
# Thresholded Event Counter

This block is one event counter of a performance monitor. On every clock it takes a small unsigned event increment and the privilege level the processor is running at. If the counter is enabled and the level is not excluded, the increment can be added to a running count. A programmable threshold test can hold back an increment. A count mode can turn each increment that passes into a single step. The count is either 32 or 64 bits wide. A sticky flag records that the count wrapped.

Configuration is held in four 32-bit registers. These are reached through a simple write port and a registered read port. Register 0 is the control word. Bit 0 enables the counter. Bit 1 selects the 64-bit width. Bit 2 selects count-by-one. Bits 4:3 hold the comparison select. Bits 7:5 exclude levels 0, 1 and 2, one bit each. Bit 8 reads back the overflow flag, and writing a 1 there clears it. Register 1 holds the threshold. Registers 2 and 3 are the low and high words of the count.

Top module: `pmu_thr_counter`

## Requirements
- R1: A synchronous reset clears the count, the overflow flag, the control word and the threshold. All of them then read back as zero.
- R2: The count changes only on cycles in which control bit 0 is set, or in which the count is written.
- R3: With a threshold of zero, every counted cycle adds its full event value, whatever the comparison select and count mode are.
- R4: With a nonzero threshold, a cycle passes when the event value meets the selected test against the threshold: 0 not equal, 1 equal, 2 greater or equal, 3 less than. A passing cycle adds the event value and a failing cycle adds nothing.
- R5: With a nonzero threshold and count-by-one set (control bit 2), a passing cycle adds exactly 1.
- R6: Level code 0, 1 or 2 on el_cur is not counted while its exclude bit (control bit 5, 6 or 7) is set. Level code 3 is never counted.
- R7: In 32-bit mode (control bit 1 clear), the count wraps at 2^32 and a carry out of bit 31 sets the overflow flag. The upper 32 bits of count_out, and register 3, read as zero.
- R8: In 64-bit mode, a carry out of bit 31 does not set the flag. The count wraps at 2^64, and a carry out of bit 63 sets the overflow flag.
- R9: A write to register 2 or 3 replaces that word of the count. The increment of that cycle is dropped.
- R10: The overflow flag stays set until the control word is written with bit 8 set. A new overflow in the same cycle wins over the clear.
- R11: When rd_en is high at a clock edge, rd_data shows the register selected by rd_addr from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_val | input | EVT_W | Event increment for this cycle |
| el_cur | input | 2 | Current privilege level (0, 1, 2; 3 is reserved) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Registered read data |
| count_out | output | 64 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A faulty comparator or count-mode path shows on count_out one cycle after the event value is driven. The bench therefore sweeps every comparison, every threshold and every event value of a 4-bit configuration, and compares after each cycle. A wrong exclusion decode shows as a missing or extra step of exactly the driven value in that same cycle. Carry, narrow-mode masking and flag faults show on count_out and ovf_flag in the cycle after the wrapping increment. A read-mux fault shows on rd_data one cycle after the read strobe.

// File: rtl/pmu_thr_pkg.sv
package pmu_thr_pkg;

  localparam int DATA_W   = 32;
  localparam int NARROW_W = 32;
  localparam int WIDE_W   = 64;

  typedef enum logic [1:0] {
    CMP_NE = 2'd0,
    CMP_EQ = 2'd1,
    CMP_GE = 2'd2,
    CMP_LT = 2'd3
  } cmp_sel_e;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_RSVD   = 2'd3
  } lvl_e;

  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_THRESH = 2'd1;
  localparam logic [1:0] REG_CNT_LO = 2'd2;
  localparam logic [1:0] REG_CNT_HI = 2'd3;

  localparam int CTRL_EN      = 0;
  localparam int CTRL_WIDE    = 1;
  localparam int CTRL_ONE     = 2;
  localparam int CTRL_CMP_LSB = 3;
  localparam int CTRL_EXC_LSB = 5;
  localparam int CTRL_OVF     = 8;

  typedef struct packed {
    logic [2:0] excl;
    cmp_sel_e   cmp;
    logic       by_one;
    logic       wide;
    logic       en;
  } cfg_t;

endpackage

// File: rtl/pmu_thr_filter.sv
module pmu_thr_filter
  import pmu_thr_pkg::*;
#(
  parameter int EVT_W = 4
) (
  input  logic [EVT_W-1:0] evt_val,
  input  logic [1:0]       el_cur,
  input  logic [2:0]       excl,
  input  cmp_sel_e         cmp,
  input  logic             by_one,
  input  logic [EVT_W-1:0] thresh,
  output logic [EVT_W-1:0] contrib
);

  localparam logic [EVT_W-1:0] ONE = EVT_W'(1);

  logic lvl_ok;
  logic cmp_ok;
  logic thr_off;

  always_comb begin
    unique case (lvl_e'(el_cur))
      LVL_USER:   lvl_ok = ~excl[0];
      LVL_KERNEL: lvl_ok = ~excl[1];
      LVL_HYP:    lvl_ok = ~excl[2];
      default:    lvl_ok = 1'b0;
    endcase
  end

  always_comb begin
    unique case (cmp)
      CMP_NE:  cmp_ok = (evt_val != thresh);
      CMP_EQ:  cmp_ok = (evt_val == thresh);
      CMP_GE:  cmp_ok = (evt_val >= thresh);
      default: cmp_ok = (evt_val <  thresh);
    endcase
  end

  assign thr_off = (thresh == '0);

  always_comb begin
    contrib = '0;
    if (lvl_ok) begin
      if (thr_off)     contrib = evt_val;
      else if (cmp_ok) contrib = by_one ? ONE : evt_val;
    end
  end

  always_comb begin
    if (!lvl_ok) AST_EXCLUDED_ZERO: assert (contrib == '0); // R6
  end

endmodule

// File: rtl/pmu_thr_accum.sv
module pmu_thr_accum
  import pmu_thr_pkg::*;
#(
  parameter int EVT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wide,
  input  logic [EVT_W-1:0]  contrib,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ovf_clr,
  output logic [WIDE_W-1:0] count,
  output logic              ovf
);

  localparam int HI_W = WIDE_W - NARROW_W;
  localparam logic [NARROW_W-1:0] STEP_LIM = NARROW_W'(1) << EVT_W;

  logic [NARROW_W:0]     sum_lo;
  logic [WIDE_W:0]       sum_all;
  logic [WIDE_W-1:0]     cnt_nxt;
  logic                  carry;

  assign sum_lo  = {1'b0, count[NARROW_W-1:0]} + {{(NARROW_W+1-EVT_W){1'b0}}, contrib};
  assign sum_all = {1'b0, count} + {{(WIDE_W+1-EVT_W){1'b0}}, contrib};

  always_comb begin
    cnt_nxt = count;
    carry   = 1'b0;
    if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_nxt[NARROW_W-1:0]      = wr_data;
      if (wr_hi) cnt_nxt[WIDE_W-1:NARROW_W] = wr_data;
    end else if (en) begin
      if (wide) begin
        cnt_nxt = sum_all[WIDE_W-1:0];
        carry   = sum_all[WIDE_W];
      end else begin
        cnt_nxt[NARROW_W-1:0] = sum_lo[NARROW_W-1:0];
        carry                 = sum_lo[NARROW_W];
      end
    end
    if (!wide) cnt_nxt[WIDE_W-1:NARROW_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= cnt_nxt;
      if (carry)        ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_lo && !wr_hi && (wide || count[WIDE_W-1:NARROW_W] == '0)) |=> $stable(count)); // R2

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (count[NARROW_W-1:0] == $past(wr_data))); // R9

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
    !wide |=> (count[WIDE_W-1:NARROW_W] == HI_W'(0))); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf); // R10

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (en && !wr_lo && !wr_hi) |=> ((count[NARROW_W-1:0] - $past(count[NARROW_W-1:0])) < STEP_LIM)); // R4

endmodule

// File: rtl/pmu_thr_regs.sv
module pmu_thr_regs
  import pmu_thr_pkg::*;
#(
  parameter int EVT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  input  logic [WIDE_W-1:0] count,
  input  logic              ovf,
  output cfg_t              cfg,
  output logic [EVT_W-1:0]  thresh,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              ovf_clr,
  output logic [DATA_W-1:0] cnt_wdata,
  output logic [DATA_W-1:0] rd_data
);

  localparam int CTRL_USED = CTRL_OVF + 1;

  logic wr_ctrl;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl   = wr_en && (wr_addr == REG_CTRL);
  assign wr_lo     = wr_en && (wr_addr == REG_CNT_LO);
  assign wr_hi     = wr_en && (wr_addr == REG_CNT_HI);
  assign ovf_clr   = wr_ctrl && wr_data[CTRL_OVF];
  assign cnt_wdata = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      thresh <= '0;
    end else if (wr_en) begin
      if (wr_addr == REG_CTRL) begin
        cfg.en     <= wr_data[CTRL_EN];
        cfg.wide   <= wr_data[CTRL_WIDE];
        cfg.by_one <= wr_data[CTRL_ONE];
        cfg.cmp    <= cmp_sel_e'(wr_data[CTRL_CMP_LSB +: 2]);
        cfg.excl   <= wr_data[CTRL_EXC_LSB +: 3];
      end else if (wr_addr == REG_THRESH) begin
        thresh <= wr_data[EVT_W-1:0];
      end
    end
  end

  always_comb begin
    unique case (rd_addr)
      REG_CTRL:   rd_mux = {{(DATA_W-CTRL_USED){1'b0}}, ovf, cfg.excl, cfg.cmp,
                            cfg.by_one, cfg.wide, cfg.en};
      REG_THRESH: rd_mux = {{(DATA_W-EVT_W){1'b0}}, thresh};
      REG_CNT_LO: rd_mux = count[NARROW_W-1:0];
      default:    rd_mux = cfg.wide ? count[WIDE_W-1:NARROW_W] : '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  AST_HI_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == REG_CNT_HI && !cfg.wide) |=> (rd_data == '0)); // R7

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R11

endmodule

// File: rtl/pmu_thr_counter.sv
module pmu_thr_counter
  import pmu_thr_pkg::*;
#(
  parameter int EVT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  evt_val,
  input  logic [1:0]        el_cur,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic [63:0]       count_out,
  output logic              ovf_flag
);

  cfg_t              cfg;
  logic [EVT_W-1:0]  thresh;
  logic [EVT_W-1:0]  contrib;
  logic              wr_lo;
  logic              wr_hi;
  logic              ovf_clr;
  logic [DATA_W-1:0] cnt_wdata;

  pmu_thr_regs #(.EVT_W(EVT_W)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .count(count_out), .ovf(ovf_flag),
    .cfg(cfg), .thresh(thresh),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .ovf_clr(ovf_clr),
    .cnt_wdata(cnt_wdata), .rd_data(rd_data)
  );

  pmu_thr_filter #(.EVT_W(EVT_W)) filt_i (
    .evt_val(evt_val), .el_cur(el_cur),
    .excl(cfg.excl), .cmp(cfg.cmp), .by_one(cfg.by_one),
    .thresh(thresh), .contrib(contrib)
  );

  pmu_thr_accum #(.EVT_W(EVT_W)) acc_i (
    .clk(clk), .rst(rst),
    .en(cfg.en), .wide(cfg.wide), .contrib(contrib),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(cnt_wdata),
    .ovf_clr(ovf_clr),
    .count(count_out), .ovf(ovf_flag)
  );

  AST_OVF_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (!ovf_flag && !cfg.en) |=> !ovf_flag); // R8

endmodule

// File: tb/pmu_thr_counter_tb_top.sv
module pmu_thr_counter_tb_top;

  localparam int EVT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [EVT_W-1:0] evt_val = '0;
  logic [1:0]       el_cur = 2'd3;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [31:0]      wr_data = '0;
  logic             rd_en = 1'b0;
  logic [1:0]       rd_addr = '0;
  logic [31:0]      rd_data;
  logic [63:0]      count_out;
  logic             ovf_flag;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_cnt = '0;
  logic [31:0] rdv;

  always #2 clk = ~clk;

  pmu_thr_counter #(.EVT_W(EVT_W)) dut_i (
    .clk(clk), .rst(rst), .evt_val(evt_val), .el_cur(el_cur),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .count_out(count_out), .ovf_flag(ovf_flag)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [63:0] model(input int cmp, input int thr, input int by1, input int e);
    logic pass;
    if (thr == 0) return 64'(e);
    case (cmp)
      0: pass = (e != thr);
      1: pass = (e == thr);
      2: pass = (e >= thr);
      default: pass = (e < thr);
    endcase
    if (!pass) return 64'd0;
    return by1 ? 64'd1 : 64'(e);
  endfunction

  function automatic logic [31:0] ctrl(input int en, input int wide, input int by1,
                                       input int cmp, input int excl, input int clr);
    return 32'(en) | (32'(wide) << 1) | (32'(by1) << 2) | (32'(cmp) << 3)
         | (32'(excl) << 5) | (32'(clr) << 8);
  endfunction

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(count_out, 64'd0, "R1 count");
    chk(64'(ovf_flag), 64'd0, "R1 ovf");
    reg_rd(2'd0, rdv); chk(64'(rdv), 64'd0, "R1 ctrl");
    reg_rd(2'd1, rdv); chk(64'(rdv), 64'd0, "R1 thresh");

    // sweep: compare select x threshold x event value x count mode, 64-bit mode
    for (int by1 = 0; by1 < 2; by1++)
      for (int cmp = 0; cmp < 4; cmp++)
        for (int thr = 0; thr < 16; thr++) begin
          el_cur = 2'd3; evt_val = '0;
          reg_wr(2'd1, 32'(thr));
          reg_wr(2'd0, ctrl(1, 1, by1, cmp, 0, 0));
          for (int e = 0; e < 16; e++) begin
            el_cur = 2'd0; evt_val = EVT_W'(e);
            exp_cnt = exp_cnt + model(cmp, thr, by1, e);
            @(negedge clk);
            chk(count_out, exp_cnt, thr == 0 ? "R3" : (by1 != 0 ? "R5" : "R4"));
          end
        end

    // level exclusion
    el_cur = 2'd3; evt_val = '0;
    reg_wr(2'd1, 32'd0);
    for (int m = 0; m < 8; m++)
      for (int l = 0; l < 4; l++) begin
        reg_wr(2'd0, ctrl(1, 1, 0, 0, m, 0));
        el_cur = 2'(l); evt_val = EVT_W'(5);
        if (l < 3 && ((m >> l) & 1) == 0) exp_cnt = exp_cnt + 64'd5;
        @(negedge clk);
        el_cur = 2'd3; evt_val = '0;
        chk(count_out, exp_cnt, "R6");
      end

    // disabled counter holds
    reg_wr(2'd0, ctrl(0, 1, 0, 0, 0, 0));
    el_cur = 2'd0; evt_val = EVT_W'(9);
    repeat (5) @(negedge clk);
    chk(count_out, exp_cnt, "R2");

    // count write beats increment
    reg_wr(2'd0, ctrl(1, 1, 0, 0, 0, 0));
    exp_cnt = exp_cnt + 64'd9;
    evt_val = EVT_W'(7);
    reg_wr(2'd2, 32'd100);
    chk(count_out, {exp_cnt[63:32], 32'd100}, "R9");
    el_cur = 2'd3; evt_val = '0;

    // 32-bit wrap
    reg_wr(2'd3, 32'd0);
    reg_wr(2'd2, 32'hFFFF_FFFE);
    reg_wr(2'd0, ctrl(1, 0, 0, 0, 0, 0));
    chk(64'(ovf_flag), 64'd0, "R7 pre");
    el_cur = 2'd0; evt_val = EVT_W'(3);
    @(negedge clk);
    el_cur = 2'd3; evt_val = '0;
    chk(count_out, 64'd1, "R7 wrap");
    chk(64'(ovf_flag), 64'd1, "R7 ovf");
    reg_rd(2'd3, rdv); chk(64'(rdv), 64'd0, "R7 hi");
    reg_rd(2'd2, rdv); chk(64'(rdv), 64'd1, "R11 lo");
    repeat (4) @(negedge clk);
    chk(64'(ovf_flag), 64'd1, "R10 sticky");
    reg_rd(2'd0, rdv); chk(64'(rdv), 64'(ctrl(1, 0, 0, 0, 0, 1)), "R10 ctrl");
    reg_wr(2'd0, ctrl(1, 0, 0, 0, 0, 1));
    chk(64'(ovf_flag), 64'd0, "R10 clear");

    // 64-bit: bit 31 carry is no overflow
    reg_wr(2'd0, ctrl(0, 1, 0, 0, 0, 0));
    reg_wr(2'd2, 32'hFFFF_FFFF);
    reg_wr(2'd0, ctrl(1, 1, 0, 0, 0, 0));
    el_cur = 2'd0; evt_val = EVT_W'(1);
    @(negedge clk);
    el_cur = 2'd3; evt_val = '0;
    chk(count_out, 64'h1_0000_0000, "R8 carry32");
    chk(64'(ovf_flag), 64'd0, "R8 no ovf");
    reg_rd(2'd3, rdv); chk(64'(rdv), 64'd1, "R11 hi");

    // 64-bit wrap
    reg_wr(2'd3, 32'hFFFF_FFFF);
    reg_wr(2'd2, 32'hFFFF_FFFF);
    el_cur = 2'd0; evt_val = EVT_W'(2);
    @(negedge clk);
    el_cur = 2'd3; evt_val = '0;
    chk(count_out, 64'd1, "R8 wrap");
    chk(64'(ovf_flag), 64'd1, "R8 ovf");

    // reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(count_out, 64'd0, "R1 rerst count");
    chk(64'(ovf_flag), 64'd0, "R1 rerst ovf");
    reg_rd(2'd0, rdv); chk(64'(rdv), 64'd0, "R1 rerst ctrl");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule